// File: doc/BRIEF.md
# Descending Register-File Stack

A last-in, first-out store built from a small array of registers. The stack pointer starts one step beyond the highest entry index. It moves down by one on every accepted push and up by one on every accepted pop. The block reports whether the stack is full or empty from the pointer value itself. A full stack has the pointer at zero. An empty stack has the pointer at the depth, which is 11 by default. There is no separate occupancy counter.

A client raises `pushReq` for one cycle with a word on `pushData`, or raises `popReq` for one cycle. A popped word appears on `popData` in the cycle after the request and stays there until the next accepted pop. The stack refuses three kinds of request: a push while full, a pop while empty, and both strobes at once. A refused request changes no stored state and raises `errPulse` for one cycle.

Top module: `down_stack`

## Requirements
- R1: After reset, `sp` equals DEPTH (11), `empty` is 1, `full` is 0, `errPulse` is 0 and `popData` is 0.
- R2: An accepted push (only `pushReq`, stack not full) makes `sp` one lower after the clock edge, stores `pushData` at the entry that the new `sp` addresses, and clears `empty` on that same edge.
- R3: `full` is 1 exactly when `sp` is 0. It rises on the edge of the push that brings `sp` to 0.
- R4: An accepted pop (only `popReq`, stack not empty) places the entry addressed by `sp` on `popData` one cycle after the request, raises `sp` by one, and clears `full` on that same edge.
- R5: `empty` is 1 exactly when `sp` equals DEPTH. It rises on the edge of the pop that brings `sp` back to DEPTH.
- R6: Pops return words in the reverse of the order in which they were pushed.
- R7: A push while `full` leaves `sp`, the flags and the stored words unchanged, and `errPulse` is 1 for exactly the following cycle.
- R8: A pop while `empty` leaves `sp`, the flags and `popData` unchanged, and `errPulse` is 1 for the following cycle.
- R9: When `pushReq` and `popReq` are high together, nothing is stored or moved, and `errPulse` is 1 for the following cycle.
- R10: `popData` keeps its value through cycles with no accepted pop, including accepted pushes. `errPulse` stays 0 after any accepted or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| pushData | input | WIDTH | Word to push |
| popData | output | WIDTH | Last popped word, registered |
| sp | output | SPW | Stack pointer (DEPTH when empty) |
| full | output | 1 | Pointer at 0 |
| empty | output | 1 | Pointer at DEPTH |
| errPulse | output | 1 | One-cycle pulse for a refused request |

## Verification
A directed fill to the top and a full drain show the pointer walking through every value from 11 to 0 and back. They also show the boundary flags rising at the right moments and that the drain returns words in reversed order. Pushes while full, pops while empty and simultaneous strobes are applied at both ends. These separate a refused request from one that was silently accepted, and they show whether the error pulse lasts one cycle. A long pseudo-random mix of pushes, pops, idles and collisions is then checked against a queue model on every clock. This mix exposes pointer drift and data that was overwritten when a push follows a pop within the same region of the array.

// File: rtl/stack_pkg.sv
package stack_pkg;
  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic doPush;
    logic doPop;
  } stackCmd_t;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl #(
  parameter int DEPTH = 11,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pushReq,
  input  logic                 popReq,
  input  logic [SPW-1:0]       sp,
  output stack_pkg::stackCmd_t cmd,
  output logic                 full,
  output logic                 empty,
  output logic                 errPulse
);
  localparam logic [SPW-1:0] SP_ONE      = SPW'(1);
  localparam logic [SPW-1:0] SP_LASTUSED = SPW'(DEPTH - 1);

  logic collide, pushRefused, popRefused;

  always_comb begin
    collide     = pushReq && popReq;
    pushRefused = pushReq && !popReq && full;
    popRefused  = popReq && !pushReq && empty;
    cmd.doPush  = pushReq && !popReq && !full;
    cmd.doPop   = popReq && !pushReq && !empty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full     <= 1'b0;
      empty    <= 1'b1;
      errPulse <= 1'b0;
    end else begin
      errPulse <= collide || pushRefused || popRefused;
      if (cmd.doPush) begin
        full  <= (sp == SP_ONE);
        empty <= 1'b0;
      end else if (cmd.doPop) begin
        full  <= 1'b0;
        empty <= (sp == SP_LASTUSED);
      end
    end
  end
endmodule

// File: rtl/stack_datapath.sv
module stack_datapath #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 11,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stack_pkg::stackCmd_t cmd,
  input  logic [WIDTH-1:0]     pushData,
  output logic [SPW-1:0]       sp,
  output logic [WIDTH-1:0]     popData
);
  localparam logic [SPW-1:0] SP_BASE = SPW'(DEPTH);

  logic [WIDTH-1:0] entry [DEPTH];
  logic [SPW-1:0]   spBelow;
  logic [WIDTH-1:0] topWord;

  assign spBelow = sp - SPW'(1);

  // One write-enabled register per stack slot.
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (cmd.doPush && (spBelow == SPW'(i))) entry[i] <= pushData;
    end
  end

  // Read the word that the current pointer addresses.
  always_comb begin
    topWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == SPW'(i)) topWord = entry[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp      <= SP_BASE;
      popData <= '0;
    end else if (cmd.doPush) begin
      sp <= spBelow;
    end else if (cmd.doPop) begin
      popData <= topWord;
      sp      <= sp + SPW'(1);
    end
  end
endmodule

// File: rtl/down_stack.sv
module down_stack #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 11,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData,
  output logic [SPW-1:0]   sp,
  output logic             full,
  output logic             empty,
  output logic             errPulse
);
  stack_pkg::stackCmd_t cmd;

  stack_ctrl #(.DEPTH(DEPTH), .SPW(SPW)) uCtrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .sp(sp),
    .cmd(cmd), .full(full), .empty(empty), .errPulse(errPulse)
  );

  stack_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SPW(SPW)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pushData(pushData),
    .sp(sp), .popData(popData)
  );
endmodule

// File: rtl/stack_checker.sv
module stack_checker #(
  parameter int DEPTH = 11,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           pushReq,
  input logic           popReq,
  input logic [SPW-1:0] sp,
  input logic           full,
  input logic           empty,
  input logic           errPulse
);
  assert_full_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    full == (sp == '0));

  assert_empty_at_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    empty == (sp == SPW'(DEPTH)));

  assert_push_moves_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && !full) |=> (sp == $past(sp) - SPW'(1)) && !empty && !errPulse);

  assert_pop_moves_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !empty) |=> (sp == $past(sp) + SPW'(1)) && !full && !errPulse);

  assert_push_when_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && full) |=> errPulse && $stable(sp) && full);

  assert_pop_when_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && empty) |=> errPulse && $stable(sp) && empty);

  assert_both_strobes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> errPulse && $stable(sp));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!pushReq && !popReq) |=> !errPulse && $stable(sp));
endmodule

bind down_stack stack_checker #(.DEPTH(DEPTH), .SPW(SPW)) uChk (
  .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .sp(sp),
  .full(full), .empty(empty), .errPulse(errPulse)
);

// File: tb/down_stack_test.sv
`timescale 1ns/1ps
module down_stack_test;
  localparam int WIDTH = 16;
  localparam int DEPTH = 11;
  localparam int SPW   = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0;
  logic [WIDTH-1:0] pushData = '0;
  logic [WIDTH-1:0] popData;
  logic [SPW-1:0]   sp;
  logic full, empty, errPulse;

  always #5 clk = ~clk;

  down_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushData(pushData), .popData(popData), .sp(sp),
    .full(full), .empty(empty), .errPulse(errPulse)
  );

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  // Reference model: a queue whose back is the top of the stack.
  int unsigned model[$];
  int unsigned expPop = 0;
  bit expErr = 0;

  task automatic check(string tag, int unsigned act, int unsigned exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(string opTag, string dataTag);
    check({opTag, " sp"}, sp, DEPTH - model.size());
    check("R3 full", full, model.size() == DEPTH);
    check("R5 empty", empty, model.size() == 0);
    check({opTag, " errPulse"}, errPulse, expErr);
    check({dataTag, " popData"}, popData, expPop);
  endtask

  // Called at a negative edge: drive, take one clock, update model, compare.
  task automatic step(bit doPush, bit doPop, logic [WIDTH-1:0] d);
    string opTag, dataTag;
    pushReq = doPush; popReq = doPop; pushData = d;
    dataTag = "R10";
    if (doPush && doPop)            begin opTag = "R9"; expErr = 1; end
    else if (doPush && model.size() == DEPTH) begin opTag = "R7"; expErr = 1; end
    else if (doPop && model.size() == 0)      begin opTag = "R8"; expErr = 1; dataTag = "R8"; end
    else if (doPush) begin opTag = "R2"; expErr = 0; model.push_back(int'(d)); end
    else if (doPop)  begin opTag = "R4"; expErr = 0; expPop = model.pop_back(); dataTag = "R4 R6"; end
    else             begin opTag = "R10"; expErr = 0; end
    @(posedge clk);
    @(negedge clk);
    compareAll(opTag, dataTag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin : stimulus
    int unsigned seed;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check("R1 sp", sp, DEPTH);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 errPulse", errPulse, 0);
    check("R1 popData", popData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Pop on an empty stack and a collision at the bottom (R8, R9)
    step(0, 1, '0);
    step(1, 1, 16'h1111);
    step(0, 0, '0);

    // Fill to the top: R2, then R3 on the eleventh push
    for (int i = 0; i < DEPTH; i++) step(1, 0, 16'hA000 + WIDTH'(i));
    check("R3 full after fill", full, 1);
    check("R3 sp after fill", sp, 0);
    step(1, 0, 16'hDEAD);          // R7 refused
    step(0, 0, '0);                // errPulse back to 0
    step(1, 1, 16'hBEEF);          // R9 at the top

    // Drain: R4, R6 reversed order, R5 at the end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step(0, 1, '0);
      check("R6 order", popData, 16'hA000 + i);
    end
    check("R5 empty after drain", empty, 1);
    step(0, 1, '0);                // R8 refused, popData holds
    check("R8 popData held", popData, 16'hA000);

    // R10: pushes do not disturb popData
    step(1, 0, 16'h0042);
    step(1, 0, 16'h0043);
    check("R10 popData held over pushes", popData, 16'hA000);
    step(0, 1, '0);
    check("R6 last in first out", popData, 16'h0043);

    // Mixed pseudo-random traffic
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      seed = seed * 1103515245 + 12345;
      r = seed >> 16;
      case (r % 8)
        0, 1, 2: step(1, 0, WIDTH'(r));
        3, 4, 5: step(0, 1, '0);
        6:       step(0, 0, '0);
        default: step(1, 1, WIDTH'(r));
      endcase
    end

    pushReq = 0; popReq = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule